// File: doc/BRIEF.md
# Bus Access Stretch Calculator

This block works out how many bus cycles one CPU access occupies, then holds the CPU off for that long. The CPU presents an access kind, a region tag for the target, a flag saying the external data bus is 8 bits wide, a flag and a 2-bit wait count for a slow chip-select, and a misalignment bit. It pulses a start strobe. The block records the resulting cycle count and drops `ready` until the last cycle of the access.

The stretch rules depend on the access class:

- **Word accesses** take two bus cycles on a narrow external bus. A misaligned word data access gains one cycle, except in internal RAM, which handles it in a single cycle.
- **Byte accesses** stretch only under a slow chip-select.
- **Free cycles and page-register writes** always take exactly one cycle.

Slow chip-select waits are charged once for every width-based bus cycle of the access.

Top module: `stretchCalc`

## Requirements
- R1: Access kind 0 (free cycle) and kind 1 (page-register write) always give a total of 1 cycle. This holds whatever the region, bus width, chip-select or misalignment inputs are.
- R2: Word kinds are 2 (program word), 3 (word read), 4 (word stack) and 5 (word write). They give a width base of 2 cycles when region is 2 (external) and `narrowBus` is 1. Otherwise their width base is 1. Region 0 is internal RAM; regions 1 and 3 are other internal memory.
- R3: Byte kinds are 6 (byte read), 7 (byte stack), 8 (byte unstack) and 9 (byte write). They give 1 cycle, or 1 + `csWait` when region is 2 and `slowCs` is 1.
- R4: For a word kind in region 2 with `slowCs` set, `csWait` × width base cycles are added on top of the width base. `slowCs` has no effect in regions 0, 1 and 3.
- R5: A misaligned access (`misaligned` = 1) of kind 3, 4 or 5 adds exactly one cycle when the region is not 0. In region 0 it adds nothing. For kind 2 the misalignment bit is ignored.
- R6: After an accepted start, `totalCycles` shows the computed count from the next cycle on. `ready` is low for `totalCycles`−1 cycles and then high for one cycle. `busy` is always the inverse of `ready`.
- R7: A `startStb` seen while `busy` is high is ignored: the count and the ready timing of the running access are unchanged. A `startStb` in a cycle where `ready` is high is accepted, including the final cycle of an access.
- R8: Kinds 10 to 15 are treated as free cycles and give 1 cycle.
- R9: After reset `ready` is 1, `busy` is 0 and `totalCycles` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startStb | input | 1 | Access start strobe |
| accKind | input | 4 | Access kind code |
| region | input | 2 | Target region tag |
| narrowBus | input | 1 | External data bus is 8 bits wide |
| slowCs | input | 1 | Target chip-select is programmed slow |
| csWait | input | WAIT_W | Extra waits per bus cycle for a slow chip-select |
| misaligned | input | 1 | Access address is odd |
| totalCycles | output | CNT_W | Cycle count of the last accepted access |
| ready | output | 1 | Access complete / block idle |
| busy | output | 1 | Access in progress |

## Verification
Two things can meet in one cycle: the final ready cycle of one access and the start strobe of the next. The bench provokes this by raising a fresh strobe in the very cycle `ready` first returns high. It then judges that the new count appears one cycle later and that the new low-ready window has the new length, with no idle cycle lost in between. A second collision is a strobe arriving mid-access. The bench checks that it leaves the running count and window untouched.

// File: rtl/stretchPkg.sv
package stretchPkg;

  typedef enum logic [3:0] {
    KIND_FREE    = 4'd0,
    KIND_PAGEWR  = 4'd1,
    KIND_PROGW   = 4'd2,
    KIND_RDW     = 4'd3,
    KIND_STKW    = 4'd4,
    KIND_WRW     = 4'd5,
    KIND_RDB     = 4'd6,
    KIND_STKB    = 4'd7,
    KIND_USTB    = 4'd8,
    KIND_WRB     = 4'd9
  } accKindE;

  localparam logic [1:0] RGN_IRAM = 2'd0;
  localparam logic [1:0] RGN_EXT  = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
  } ctrlStbS;

endpackage

// File: rtl/stretchClassify.sv
module stretchClassify
  import stretchPkg::*;
(
  input  logic [3:0] accKind,
  output logic       isWord,
  output logic       isDataWord,
  output logic       isByte
);
  always_comb begin
    isWord     = 1'b0;
    isDataWord = 1'b0;
    isByte     = 1'b0;
    case (accKind)
      KIND_PROGW:                  isWord = 1'b1;
      KIND_RDW, KIND_STKW, KIND_WRW: begin
        isWord     = 1'b1;
        isDataWord = 1'b1;
      end
      KIND_RDB, KIND_STKB, KIND_USTB, KIND_WRB: isByte = 1'b1;
      default: ; // free, page write and reserved codes take one cycle
    endcase
  end
endmodule

// File: rtl/stretchDatapath.sv
module stretchDatapath
  import stretchPkg::*;
#(
  parameter int WAIT_W = 2,
  parameter int CNT_W  = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStbS           ctrlStb,
  input  logic [3:0]        accKind,
  input  logic [1:0]        region,
  input  logic              narrowBus,
  input  logic              slowCs,
  input  logic [WAIT_W-1:0] csWait,
  input  logic              misaligned,
  output logic [CNT_W-1:0]  calcTotal,
  output logic [CNT_W-1:0]  totalCycles
);
  logic isWord, isDataWord, isByte;
  logic isExt, dblWidth, misAdd, csApply;
  logic [CNT_W-1:0] widthBase, csExtra, waitWide;

  stretchClassify u_cls (
    .accKind   (accKind),
    .isWord    (isWord),
    .isDataWord(isDataWord),
    .isByte    (isByte)
  );

  assign isExt    = (region == RGN_EXT);
  assign dblWidth = isWord && isExt && narrowBus;
  assign misAdd   = isDataWord && misaligned && (region != RGN_IRAM);
  assign csApply  = (isWord || isByte) && isExt && slowCs;
  assign waitWide = CNT_W'(csWait);

  always_comb begin
    widthBase = dblWidth ? CNT_W'(2) : CNT_W'(1);
    csExtra   = '0;
    if (csApply) csExtra = dblWidth ? (waitWide << 1) : waitWide;
    if (isWord || isByte)
      calcTotal = widthBase + csExtra + CNT_W'(misAdd);
    else
      calcTotal = CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              totalCycles <= '0;
    else if (ctrlStb.accept) totalCycles <= calcTotal;
  end
endmodule

// File: rtl/stretchControl.sv
module stretchControl
  import stretchPkg::*;
#(
  parameter int CNT_W = 4
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startStb,
  input  logic [CNT_W-1:0] calcTotal,
  output ctrlStbS          ctrlStb,
  output logic             ready,
  output logic             busy
);
  logic [CNT_W-1:0] remain;
  logic idle;

  assign idle           = (remain == '0);
  assign ctrlStb.accept = startStb && idle;
  assign ready          = idle;
  assign busy           = !idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (ctrlStb.accept) remain <= calcTotal - CNT_W'(1);
    else if (!idle)          remain <= remain - CNT_W'(1);
  end
endmodule

// File: rtl/stretchCalc.sv
module stretchCalc
  import stretchPkg::*;
#(
  parameter int WAIT_W = 2,
  localparam int MAX_TOTAL = 3 + 2 * ((1 << WAIT_W) - 1),
  localparam int CNT_W = $clog2(MAX_TOTAL + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startStb,
  input  logic [3:0]        accKind,
  input  logic [1:0]        region,
  input  logic              narrowBus,
  input  logic              slowCs,
  input  logic [WAIT_W-1:0] csWait,
  input  logic              misaligned,
  output logic [CNT_W-1:0]  totalCycles,
  output logic              ready,
  output logic              busy
);
  ctrlStbS ctrlStb;
  logic [CNT_W-1:0] calcTotal;

  stretchDatapath #(.WAIT_W(WAIT_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrlStb(ctrlStb),
    .accKind(accKind), .region(region), .narrowBus(narrowBus),
    .slowCs(slowCs), .csWait(csWait), .misaligned(misaligned),
    .calcTotal(calcTotal), .totalCycles(totalCycles)
  );

  stretchControl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .startStb(startStb),
    .calcTotal(calcTotal), .ctrlStb(ctrlStb),
    .ready(ready), .busy(busy)
  );
endmodule

// File: rtl/stretchChecker.sv
module stretchChecker #(
  parameter int WAIT_W = 2,
  parameter int CNT_W  = 4
)(
  input logic              clk,
  input logic              rst_n,
  input logic              startStb,
  input logic [3:0]        accKind,
  input logic [1:0]        region,
  input logic              misaligned,
  input logic [CNT_W-1:0]  totalCycles,
  input logic              ready,
  input logic              busy
);
  localparam int MAX_TOTAL = 3 + 2 * ((1 << WAIT_W) - 1);

  AST_FREE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (startStb && ready && accKind <= 4'd1) |=> (totalCycles == CNT_W'(1) && ready)); // R1

  AST_RESERVED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (startStb && ready && accKind >= 4'd10) |=> (totalCycles == CNT_W'(1))); // R8

  AST_BYTE_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
    (startStb && ready && accKind >= 4'd6 && accKind <= 4'd9 && region != 2'd2)
      |=> (totalCycles == CNT_W'(1))); // R3

  AST_IRAM_MISALIGN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (startStb && ready && accKind >= 4'd2 && accKind <= 4'd5 && region == 2'd0 && misaligned)
      |=> (totalCycles == CNT_W'(1))); // R5

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(totalCycles)); // R7

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !startStb) |=> ready); // R6

  AST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (startStb && ready) |=> (totalCycles >= CNT_W'(1) && int'(totalCycles) <= MAX_TOTAL)); // R6

  AST_BUSY_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    busy != ready); // R6
endmodule

bind stretchCalc stretchChecker #(.WAIT_W(WAIT_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .startStb(startStb), .accKind(accKind),
  .region(region), .misaligned(misaligned), .totalCycles(totalCycles),
  .ready(ready), .busy(busy)
);

// File: tb/stretchCalc_tb.sv
module stretchCalc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startStb = 1'b0;
  logic [3:0] accKind = '0;
  logic [1:0] region = '0;
  logic narrowBus = 1'b0, slowCs = 1'b0, misaligned = 1'b0;
  logic [WAIT_W-1:0] csWait = '0;
  logic [3:0] totalCycles;
  logic ready, busy;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stretchCalc #(.WAIT_W(WAIT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .startStb(startStb), .accKind(accKind),
    .region(region), .narrowBus(narrowBus), .slowCs(slowCs),
    .csWait(csWait), .misaligned(misaligned),
    .totalCycles(totalCycles), .ready(ready), .busy(busy)
  );

  function automatic int expCycles(int k, int r, bit nb, bit sc, int w, bit mis);
    bit wordK, byteK, ext;
    int base, t;
    wordK = (k >= 2 && k <= 5);
    byteK = (k >= 6 && k <= 9);
    ext   = (r == 2);
    if (!wordK && !byteK) return 1;          // R1, R8
    base = (wordK && ext && nb) ? 2 : 1;     // R2
    t = base;
    if (k >= 3 && k <= 5 && mis && r != 0) t = t + 1;  // R5
    if (ext && sc) t = t + w * base;         // R3, R4
    return t;
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setIn(int k, int r, bit nb, bit sc, int w, bit mis);
    accKind = 4'(k); region = 2'(r); narrowBus = nb;
    slowCs = sc; csWait = WAIT_W'(w); misaligned = mis;
  endtask

  // measure low-ready window starting at a negedge just after acceptance
  task automatic measure(string req, int exp);
    int low;
    low = 0;
    check(req, int'(totalCycles), exp);
    while (!ready && low < 32) begin
      check("R6 busy", int'(busy), 1);
      low++;
      @(negedge clk);
    end
    check("R6 window", low, exp - 1);
  endtask

  task automatic runAccess(string req, int k, int r, bit nb, bit sc, int w, bit mis);
    @(negedge clk);
    setIn(k, r, nb, sc, w, mis);
    startStb = 1'b1;
    @(negedge clk);
    startStb = 1'b0;
    measure(req, expCycles(k, r, nb, sc, w, mis));
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check("R9 ready", int'(ready), 1);
    check("R9 busy", int'(busy), 0);
    check("R9 total", int'(totalCycles), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    runAccess("R1 free", 0, 2, 1, 1, 3, 1);
    runAccess("R1 pagewr", 1, 2, 1, 1, 3, 1);
    runAccess("R8 reserved", 12, 2, 1, 1, 3, 1);
    runAccess("R2 progw narrow ext", 2, 2, 1, 0, 0, 0);
    runAccess("R2 word wide ext", 3, 2, 0, 0, 0, 0);
    runAccess("R2 word narrow internal", 5, 1, 1, 0, 0, 0);
    runAccess("R3 byte slow ext", 6, 2, 1, 1, 3, 0);
    runAccess("R3 byte slow internal", 9, 1, 1, 1, 3, 1);
    runAccess("R4 word narrow slow", 4, 2, 1, 1, 3, 1);
    runAccess("R4 slowCs internal", 3, 3, 1, 1, 2, 0);
    runAccess("R5 misalign iram", 4, 0, 1, 1, 3, 1);
    runAccess("R5 misalign internal", 5, 1, 0, 0, 0, 1);
    runAccess("R5 progw misalign", 2, 1, 0, 0, 0, 1);

    // R7: strobe while busy is ignored
    @(negedge clk);
    setIn(4, 2, 1, 1, 3, 1);
    startStb = 1'b1;
    @(negedge clk);
    setIn(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    startStb = 1'b0;
    check("R7 ignored total", int'(totalCycles), 9);
    begin
      int low;
      low = 1;
      while (!ready && low < 32) begin low++; @(negedge clk); end
      check("R7 ignored window", low, 8);
    end
    // R7: back-to-back start in the final ready cycle
    setIn(3, 2, 1, 1, 1, 0);
    startStb = 1'b1;
    @(negedge clk);
    startStb = 1'b0;
    measure("R7 back-to-back", 4);
    setIn(7, 2, 0, 1, 2, 0);
    startStb = 1'b1;
    @(negedge clk);
    startStb = 1'b0;
    measure("R7 back-to-back byte", 3);

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      int k, r, w;
      bit nb, sc, mis;
      k = int'($urandom_range(0, 15));
      r = int'($urandom_range(0, 3));
      w = int'($urandom_range(0, 3));
      nb = 1'($urandom); sc = 1'($urandom); mis = 1'($urandom);
      runAccess("R2 R3 R4 R5 random", k, r, nb, sc, w, mis);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule